// File: doc/BRIEF.md
# Memory Map and Device-Select Decoder

This block turns the 16-bit address bus of a small 8-bit computer, together with its read and write strobes, into chip selects. Four active-high selects cover the memory regions: the first 32K RAM, a switchable 8K bank window, a system RAM area, and a 16K region that holds the boot image. The 512-byte I/O page just below the boot image is cut into sixteen card slots of 32 bytes. Each slot gets its own active-low select line. Each card sees only its select line, the five low address bits passed through by this block, and the bus strobes.

Every card reports an 8-bit identity at its slot base. When the CPU reads a slot's base address, the block drives a separate active-low ID-request strobe. A fixed-direction buffer can then put the card's identity on the data bus. A 4-bit encoded slot number sits beside the one-hot device selects.

All outputs are purely combinational. This is address decoding, not a data stream, so there is no valid/ready handshake and no back-pressure. The strobes alone qualify the selects.

Top module: `mmap_decoder`

## Requirements
- R1: While read or write is high, `ram0_sel_o` is 1 exactly for addresses 0x0000 to 0x7FFF.
- R2: While read or write is high, `bank_sel_o` is 1 exactly for addresses 0x8000 to 0x9FFF.
- R3: While read or write is high, `sysram_sel_o` is 1 exactly for addresses 0xA000 to 0xBDFF.
- R4: While read or write is high, `rom_sel_o` is 1 exactly for addresses 0xC000 to 0xFFFF.
- R5: While read or write is high and the address lies in 0xBE00 to 0xBFFF, only bit n of `dev_sel_n_o` is 0, where n = address bits [8:5]. That is slot n, spanning 0xBE00 + 32·n to 0xBE00 + 32·n + 31. Otherwise all sixteen bits are 1.
- R6: With both read and write low, all four memory selects are 0, `dev_sel_n_o` is all ones and `id_req_n_o` is 1, whatever the address.
- R7: For every input combination, no more than one select is active across the four memory selects and the sixteen device selects.
- R8: `id_req_n_o` is 0 exactly when read is high, the address is in 0xBE00 to 0xBFFF, and address bits [4:0] are all zero. A write alone to a slot base leaves it at 1.
- R9: `dev_addr_o` always equals address bits [4:0].
- R10: `slot_num_o` equals address bits [8:5] when the address is in the I/O page, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | CPU address bus |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| ram0_sel_o | output | 1 | First 32K RAM select |
| bank_sel_o | output | 1 | 8K bank window select |
| sysram_sel_o | output | 1 | System RAM select |
| rom_sel_o | output | 1 | Boot image region select |
| dev_sel_n_o | output | 16 | Per-slot device selects, active low |
| id_req_n_o | output | 1 | Identity read strobe, active low |
| slot_num_o | output | 4 | Encoded slot number |
| dev_addr_o | output | 5 | Low address bits for the cards |

## Verification
The decoder holds no state. A wrong region boundary or slot comparison therefore shows at the ports in the same cycle the address is presented. It appears as a missing select, a doubled select or a select on the wrong slot. The bench applies every address under read-only and write-only strobes, and applies a strided subset with no strobe and with both strobes. Off-by-one boundaries and wrong slot indices therefore show up on the exact address where they occur.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  typedef enum logic [2:0] {
    RGN_NONE   = 3'd0,
    RGN_RAM0   = 3'd1,
    RGN_BANK   = 3'd2,
    RGN_SYSRAM = 3'd3,
    RGN_IO     = 3'd4,
    RGN_ROM    = 3'd5
  } region_e;
endpackage

// File: rtl/mmap_region_dec.sv
module mmap_region_dec
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BANK_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] SYS_BASE  = 16'hA000,
  parameter logic [ADDR_W-1:0] IO_BASE   = 16'hBE00,
  parameter int PAGE_BYTES = 512
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);
  localparam logic [ADDR_W:0] BANK_W = {1'b0, BANK_BASE};
  localparam logic [ADDR_W:0] SYS_W  = {1'b0, SYS_BASE};
  localparam logic [ADDR_W:0] IO_W   = {1'b0, IO_BASE};
  localparam logic [ADDR_W:0] IO_END = IO_W + (ADDR_W+1)'(PAGE_BYTES);

  logic [ADDR_W:0] a_ext;
  assign a_ext = {1'b0, addr_i};

  always_comb begin
    if (a_ext < BANK_W)      region_o = RGN_RAM0;
    else if (a_ext < SYS_W)  region_o = RGN_BANK;
    else if (a_ext < IO_W)   region_o = RGN_SYSRAM;
    else if (a_ext < IO_END) region_o = RGN_IO;
    else                     region_o = RGN_ROM;
  end
endmodule

// File: rtl/mmap_slot_dec.sv
module mmap_slot_dec #(
  parameter int SLOT_COUNT = 16,
  localparam int SLOT_BITS = $clog2(SLOT_COUNT)
) (
  input  logic                  enable_i,
  input  logic                  in_page_i,
  input  logic [SLOT_BITS-1:0]  slot_idx_i,
  output logic [SLOT_COUNT-1:0] sel_n_o,
  output logic [SLOT_BITS-1:0]  slot_num_o
);
  for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_slot
    assign sel_n_o[g] = ~(enable_i && in_page_i &&
                          (slot_idx_i == SLOT_BITS'(g)));
  end

  assign slot_num_o = in_page_i ? slot_idx_i : '0;
endmodule

// File: rtl/mmap_id_strobe.sv
module mmap_id_strobe #(
  parameter int OFS_BITS = 5
) (
  input  logic                rd_i,
  input  logic                in_page_i,
  input  logic [OFS_BITS-1:0] offset_i,
  output logic                id_req_n_o
);
  assign id_req_n_o = ~(rd_i && in_page_i && (offset_i == '0));
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SLOT_COUNT = 16,
  parameter int SLOT_BYTES = 32,
  parameter logic [ADDR_W-1:0] BANK_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] SYS_BASE  = 16'hA000,
  parameter logic [ADDR_W-1:0] IO_BASE   = 16'hBE00,
  localparam int SLOT_LSB   = $clog2(SLOT_BYTES),
  localparam int SLOT_BITS  = $clog2(SLOT_COUNT),
  localparam int PAGE_BYTES = SLOT_COUNT * SLOT_BYTES
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  output logic                  ram0_sel_o,
  output logic                  bank_sel_o,
  output logic                  sysram_sel_o,
  output logic                  rom_sel_o,
  output logic [SLOT_COUNT-1:0] dev_sel_n_o,
  output logic                  id_req_n_o,
  output logic [SLOT_BITS-1:0]  slot_num_o,
  output logic [SLOT_LSB-1:0]   dev_addr_o
);
  region_e region;
  logic    bus_active;
  logic    in_page;

  assign bus_active = rd_i | wr_i;

  mmap_region_dec #(
    .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE), .SYS_BASE(SYS_BASE),
    .IO_BASE(IO_BASE), .PAGE_BYTES(PAGE_BYTES)
  ) u_region (
    .addr_i  (addr_i),
    .region_o(region)
  );

  assign in_page      = (region == RGN_IO);
  assign ram0_sel_o   = bus_active && (region == RGN_RAM0);
  assign bank_sel_o   = bus_active && (region == RGN_BANK);
  assign sysram_sel_o = bus_active && (region == RGN_SYSRAM);
  assign rom_sel_o    = bus_active && (region == RGN_ROM);

  mmap_slot_dec #(.SLOT_COUNT(SLOT_COUNT)) u_slots (
    .enable_i  (bus_active),
    .in_page_i (in_page),
    .slot_idx_i(addr_i[SLOT_LSB +: SLOT_BITS]),
    .sel_n_o   (dev_sel_n_o),
    .slot_num_o(slot_num_o)
  );

  mmap_id_strobe #(.OFS_BITS(SLOT_LSB)) u_id (
    .rd_i      (rd_i),
    .in_page_i (in_page),
    .offset_i  (addr_i[SLOT_LSB-1:0]),
    .id_req_n_o(id_req_n_o)
  );

  assign dev_addr_o = addr_i[SLOT_LSB-1:0];
endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk #(
  parameter int ADDR_W     = 16,
  parameter int SLOT_COUNT = 16,
  parameter int SLOT_BITS  = 4,
  parameter int SLOT_LSB   = 5
) (
  input logic [ADDR_W-1:0]     addr_i,
  input logic                  rd_i,
  input logic                  wr_i,
  input logic                  ram0_sel_o,
  input logic                  bank_sel_o,
  input logic                  sysram_sel_o,
  input logic                  rom_sel_o,
  input logic [SLOT_COUNT-1:0] dev_sel_n_o,
  input logic                  id_req_n_o,
  input logic [SLOT_BITS-1:0]  slot_num_o,
  input logic [SLOT_LSB-1:0]   dev_addr_o
);
  always_comb begin
    // R7: at most one select across memory and device lines
    a_r7_single_select: assert ($countones({ram0_sel_o, bank_sel_o, sysram_sel_o,
                                            rom_sel_o, ~dev_sel_n_o}) <= 1);
    // R6: idle bus drives nothing
    if (!rd_i && !wr_i) begin
      a_r6_idle_quiet: assert (!ram0_sel_o && !bank_sel_o && !sysram_sel_o &&
                               !rom_sel_o && (&dev_sel_n_o) && id_req_n_o);
    end
    // R8: identity strobe never without read
    if (!rd_i) begin
      a_r8_id_needs_read: assert (id_req_n_o);
    end
    // R8: identity strobe only on a slot base offset
    if (!id_req_n_o) begin
      a_r8_id_at_base: assert (dev_addr_o == '0);
    end
    // R9: low bits passed through
    a_r9_addr_pass: assert (dev_addr_o == addr_i[SLOT_LSB-1:0]);
    // R5/R10: active device line agrees with encoded slot number
    if (!(&dev_sel_n_o)) begin
      a_r10_slot_matches: assert (~dev_sel_n_o ==
                                  (SLOT_COUNT'(1) << slot_num_o));
    end
  end
endmodule

bind mmap_decoder mmap_decoder_chk #(
  .ADDR_W(ADDR_W), .SLOT_COUNT(SLOT_COUNT),
  .SLOT_BITS(SLOT_BITS), .SLOT_LSB(SLOT_LSB)
) u_chk (.*);

// File: tb/mmap_decoder_bench.sv
module mmap_decoder_bench;
  logic        clk = 1'b0;
  logic [15:0] addr;
  logic        rd, wr;
  logic        ram0, bank, sysram, rom, id_n;
  logic [15:0] dsel_n;
  logic [3:0]  slot;
  logic [4:0]  daddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  mmap_decoder u_mmap_decoder (
    .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .ram0_sel_o(ram0), .bank_sel_o(bank), .sysram_sel_o(sysram),
    .rom_sel_o(rom), .dev_sel_n_o(dsel_n), .id_req_n_o(id_n),
    .slot_num_o(slot), .dev_addr_o(daddr)
  );

  task automatic chk(input string req, input int act, input int exp, input int a);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s addr=%h rd=%0d wr=%0d actual=%h expected=%h",
               req, a[15:0], rd, wr, act, exp);
    end
  endtask

  task automatic apply(input int a, input bit r, input bit w);
    bit act, pg;
    int e_dev, e_slot;
    @(negedge clk);
    addr = a[15:0]; rd = r; wr = w;
    @(posedge clk);
    act = r | w;
    pg  = (a >= 'hBE00) && (a < 'hC000);
    e_slot = pg ? (a - 'hBE00) / 32 : 0;
    e_dev  = (act && pg) ? ('hFFFF & ~(1 << e_slot)) : 'hFFFF;
    chk("R1", int'(ram0),   int'(act && a < 'h8000), a);
    chk("R2", int'(bank),   int'(act && a >= 'h8000 && a < 'hA000), a);
    chk("R3", int'(sysram), int'(act && a >= 'hA000 && a < 'hBE00), a);
    chk("R4", int'(rom),    int'(act && a >= 'hC000), a);
    chk("R5", int'(dsel_n), e_dev, a);
    chk("R8", int'(id_n),   int'(!(r && pg && (a % 32) == 0)), a);
    chk("R9", int'(daddr),  a % 32, a);
    chk("R10", int'(slot),  e_slot, a);
    chk("R7", int'($countones({ram0, bank, sysram, rom, ~dsel_n}) <= 1), 1, a);
    if (!act)
      chk("R6", int'({ram0, bank, sysram, rom, &dsel_n, id_n}), 'b000011, a);
  endtask

  initial begin
    addr = '0; rd = 0; wr = 0;
    @(posedge clk);
    // reset-like idle state: nothing selected (R6)
    chk("R6", int'({ram0, bank, sysram, rom, &dsel_n, id_n}), 'b000011, 0);
    for (int a = 0; a < 65536; a++) apply(a, 1'b1, 1'b0);
    for (int a = 0; a < 65536; a++) apply(a, 1'b0, 1'b1);
    for (int a = 0; a < 65536; a += 16) begin
      apply(a, 1'b0, 1'b0);
      apply(a, 1'b1, 1'b1);
    end
    // explicit boundaries: slot bases, write to base (R8), page edges (R3/R4/R5)
    apply('hBDFF, 1'b1, 1'b0);
    apply('hBE00, 1'b0, 1'b1);
    apply('hBFE0, 1'b1, 1'b0);
    apply('hBFFF, 1'b1, 1'b0);
    apply('hC000, 1'b0, 1'b1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule